// File: doc/BRIEF.md
# APB Requester Transfer Engine

This block is the requester side of an APB bus segment. A local agent hands it one command at a time: a byte address, a direction, write data, byte-lane enables and a three-bit protection attribute. The engine works out which completer owns the address and raises that completer's select line. It then runs the transfer through a setup phase and an access phase, and it stretches the access phase for as long as the completer holds ready low. The read data and the completer's fault flag come back on a response strobe.

The command port is a valid/ready stream. The agent raises `cmd_valid` with stable fields and holds them until it sees `cmd_ready` high at a rising edge. The engine accepts a command only when it can start it on the bus at once. That happens in one of two cases: the bus is idle and the wake-up line is already high, or the current transfer is completing and the new address maps to a completer. The response port has no back-pressure. Only one transfer is ever in flight and at most one response is produced per cycle, so `rsp_valid` is a one-cycle strobe and the agent must take it when it appears. The engine also drives a wake-up line from a flop. This line announces bus activity to the power and clock control logic ahead of any select.

Top module: `apb_req_engine`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next state has every select low, enable low, wake-up low, `rsp_valid` low and the address output zero.
- R2: A setup cycle (a select high, enable low) lasts exactly one clock. The following cycle keeps the same select and raises enable.
- R3: While an access cycle sees `bus_rdy` low, the next cycle stays in access, and select, address, direction, write data, byte mask and attribute are all unchanged.
- R4: When an access cycle sees `bus_rdy` high and a command that maps to a completer is valid, the engine accepts it in that cycle and the next cycle is its setup cycle, with the new address, direction and write data. Otherwise the next cycle has all selects and enable low.
- R5: During a read transfer the byte mask output is all zero. During a write it equals the command's `cmd_strb`, where bit n enables data bits 8n+7 down to 8n.
- R6: In the cycle after a completing access cycle, `rsp_valid` is high and `rsp_err` equals the `bus_fault` seen in the completing cycle, for reads and writes alike. `rsp_rdata` equals the `bus_rdata` seen then for a read, and zero for a write. `rsp_valid` is high in no other cycle except the one named in R11.
- R7: Whenever any select is high, the wake-up output is high, and it stays high until the access cycle that sees `bus_rdy` high.
- R8: A select never rises unless wake-up was high in the previous cycle. In an idle cycle with wake-up low, `cmd_ready` is low.
- R9: If a cycle has `cmd_valid` low and no transfer that continues past that cycle, the wake-up output is low in the next cycle.
- R10: Completer decode uses a table of power-of-two regions. With the defaults, completer 0 owns 0x0000–0x0FFF, completer 1 owns 0x1000–0x1FFF, completer 2 owns 0x0000–0x3FFF and completer 3 owns 0x8000–0xBFFF. Where regions overlap, the lowest index wins. At most one select is high at any time.
- R11: A command that hits no region is accepted only from idle. In the next cycle no select is raised, `rsp_valid` and `rsp_err` are high, and `rsp_rdata` is zero.
- R12: A command is accepted only in an idle cycle or in a completing access cycle. A command that misses every region is not accepted in a completing access cycle.
- R13: The attribute output carries the command's `cmd_prot` unchanged for the whole transfer: bit 0 privileged, bit 1 non-secure, bit 2 instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all activity on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken at this edge when valid is also high |
| cmd_addr | input | ADDR_W | Byte address of the command |
| cmd_write | input | 1 | 1 for a write, 0 for a read |
| cmd_wdata | input | DATA_W | Write data |
| cmd_strb | input | DATA_W/8 | Byte-lane enables for a write |
| cmd_prot | input | 3 | Protection attribute |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DATA_W | Read data, zero for writes and misses |
| rsp_err | output | 1 | Fault status of the finished command |
| bus_sel | output | N_COMP | One select per completer |
| bus_en | output | 1 | High in access cycles |
| bus_addr | output | ADDR_W | Transfer address |
| bus_wr | output | 1 | Transfer direction |
| bus_wdata | output | DATA_W | Transfer write data |
| bus_bytemask | output | DATA_W/8 | Transfer byte mask |
| bus_attr | output | 3 | Transfer protection attribute |
| bus_wake | output | 1 | Registered wake-up indication |
| bus_rdy | input | 1 | Completer ready |
| bus_rdata | input | DATA_W | Completer read data |
| bus_fault | input | 1 | Completer error flag |

## Verification
The bench goes after back-to-back commands offered in the completing cycle. A design that passes through idle there loses a cycle and breaks R4, and one that accepts an unmapped command there collides two responses in one cycle. It stretches access phases by zero to three wait cycles and compares every bus output across each stall. A design that reloads its holding registers on any offered command would change the address or data under a waiting completer. It probes overlapping and unmapped addresses at region edges, such as 0x0FFF against 0x1000 or 0x3FFC against 0x4000, where an off-by-one or reversed priority picks the wrong select. It also watches wake-up before the first select and after the last completion, where a comb-driven or one-cycle-late line would either trail the select or stay up with nothing queued.

// File: rtl/apbr_pkg.sv
package apbr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2
  } phase_e;
endpackage

// File: rtl/apbr_decode.sv
module apbr_decode #(
  parameter int ADDR_W = 32,
  parameter int N_COMP = 4,
  parameter logic [N_COMP*ADDR_W-1:0] BASES = '0,
  parameter logic [N_COMP*ADDR_W-1:0] SIZES = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [N_COMP-1:0] sel_oh
);
  logic [N_COMP-1:0] match;

  for (genvar g = 0; g < N_COMP; g++) begin : g_region
    localparam logic [ADDR_W-1:0] RBASE = BASES[g*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] RSIZE = SIZES[g*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] RMASK = ~(RSIZE - ADDR_W'(1));
    assign match[g] = ((addr & RMASK) == RBASE);
  end

  // lowest index wins where regions overlap
  always_comb begin
    sel_oh = '0;
    for (int i = N_COMP - 1; i >= 0; i--) begin
      if (match[i]) begin
        sel_oh    = '0;
        sel_oh[i] = 1'b1;
      end
    end
  end

  assign hit = |match;
endmodule

// File: rtl/apbr_wake.sv
module apbr_wake
  import apbr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cmd_valid,
  input  phase_e phase,
  input  logic   bus_rdy,
  output logic   wake
);
  logic wake_d;

  // keep the line up while work is queued or a transfer is still running
  assign wake_d = cmd_valid
                | (phase == PH_SETUP)
                | ((phase == PH_ACCESS) & ~bus_rdy);

  always_ff @(posedge clk) begin
    if (!rst_n) wake <= 1'b0;
    else        wake <= wake_d;
  end

  assert_wake_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase != PH_IDLE) && !((phase == PH_ACCESS) && bus_rdy)) |=> wake);
endmodule

// File: rtl/apbr_phase.sv
module apbr_phase
  import apbr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int STRB_W = DATA_W / 8,
  parameter int N_COMP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_write,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [STRB_W-1:0] cmd_strb,
  input  logic [2:0]        cmd_prot,
  input  logic              hit,
  input  logic [N_COMP-1:0] sel_oh,
  input  logic              wake,
  output phase_e            phase,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic [N_COMP-1:0] bus_sel,
  output logic              bus_en,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_wr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [STRB_W-1:0] bus_bytemask,
  output logic [2:0]        bus_attr,
  input  logic              bus_rdy,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_fault
);
  phase_e phase_nx;
  logic   done, take;

  assign done      = (phase == PH_ACCESS) & bus_rdy;
  assign cmd_ready = ((phase == PH_IDLE) & wake) | (done & hit);
  assign take      = cmd_valid & cmd_ready;

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_IDLE:   if (take && hit) phase_nx = PH_SETUP;
      PH_SETUP:  phase_nx = PH_ACCESS;
      PH_ACCESS: if (done) phase_nx = take ? PH_SETUP : PH_IDLE;
      default:   phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase        <= PH_IDLE;
      bus_sel      <= '0;
      bus_addr     <= '0;
      bus_wr       <= 1'b0;
      bus_wdata    <= '0;
      bus_bytemask <= '0;
      bus_attr     <= '0;
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '0;
      rsp_err      <= 1'b0;
    end else begin
      phase     <= phase_nx;
      rsp_valid <= done | (take & ~hit);
      if (take && hit) begin
        bus_sel      <= sel_oh;
        bus_addr     <= cmd_addr;
        bus_wr       <= cmd_write;
        bus_wdata    <= cmd_wdata;
        bus_bytemask <= cmd_write ? cmd_strb : '0;
        bus_attr     <= cmd_prot;
      end else if (done) begin
        bus_sel <= '0;
      end
      if (done) begin
        rsp_err   <= bus_fault;
        rsp_rdata <= bus_wr ? '0 : bus_rdata;
      end else if (take && !hit) begin
        rsp_err   <= 1'b1;
        rsp_rdata <= '0;
      end
    end
  end

  assign bus_en = (phase == PH_ACCESS);

  assert_setup_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SETUP) |=> (bus_en && $stable(bus_sel)));

  assert_hold_in_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_ACCESS) && !bus_rdy) |=>
      (bus_en && $stable(bus_sel) && $stable(bus_addr) && $stable(bus_wr) &&
       $stable(bus_wdata) && $stable(bus_bytemask) && $stable(bus_attr)));

  assert_read_mask_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|bus_sel) && !bus_wr) |-> (bus_bytemask == '0));

  assert_rsp_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rsp_valid);

  assert_single_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_sel));

  assert_miss_local_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !hit) |=> (bus_sel == '0 && rsp_valid && rsp_err));

  assert_accept_window_R12: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ((phase == PH_IDLE) || done));
endmodule

// File: rtl/apb_req_engine.sv
module apb_req_engine
  import apbr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int N_COMP = 4,
  parameter logic [N_COMP*ADDR_W-1:0] BASES =
    {32'h0000_8000, 32'h0000_0000, 32'h0000_1000, 32'h0000_0000},
  parameter logic [N_COMP*ADDR_W-1:0] SIZES =
    {32'h0000_4000, 32'h0000_4000, 32'h0000_1000, 32'h0000_1000}
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic [ADDR_W-1:0]     cmd_addr,
  input  logic                  cmd_write,
  input  logic [DATA_W-1:0]     cmd_wdata,
  input  logic [DATA_W/8-1:0]   cmd_strb,
  input  logic [2:0]            cmd_prot,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic                  rsp_err,
  output logic [N_COMP-1:0]     bus_sel,
  output logic                  bus_en,
  output logic [ADDR_W-1:0]     bus_addr,
  output logic                  bus_wr,
  output logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W/8-1:0]   bus_bytemask,
  output logic [2:0]            bus_attr,
  output logic                  bus_wake,
  input  logic                  bus_rdy,
  input  logic [DATA_W-1:0]     bus_rdata,
  input  logic                  bus_fault
);
  localparam int STRB_W = DATA_W / 8;

  logic              hit;
  logic [N_COMP-1:0] sel_oh;
  phase_e            phase;

  apbr_decode #(
    .ADDR_W(ADDR_W), .N_COMP(N_COMP), .BASES(BASES), .SIZES(SIZES)
  ) u_decode (
    .addr(cmd_addr), .hit(hit), .sel_oh(sel_oh)
  );

  apbr_wake u_wake (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .phase(phase), .bus_rdy(bus_rdy), .wake(bus_wake)
  );

  apbr_phase #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STRB_W(STRB_W), .N_COMP(N_COMP)
  ) u_phase (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_write(cmd_write), .cmd_wdata(cmd_wdata),
    .cmd_strb(cmd_strb), .cmd_prot(cmd_prot),
    .hit(hit), .sel_oh(sel_oh), .wake(bus_wake), .phase(phase),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .bus_sel(bus_sel), .bus_en(bus_en), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_bytemask(bus_bytemask), .bus_attr(bus_attr),
    .bus_rdy(bus_rdy), .bus_rdata(bus_rdata), .bus_fault(bus_fault)
  );

  // select and wake come from different submodules
  assert_select_has_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|bus_sel) |-> bus_wake);

  assert_rise_after_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_sel == '0) && !bus_wake) |=> (bus_sel == '0));
endmodule

// File: tb/sim_apb_req_engine.sv
module sim_apb_req_engine;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int SW = 4;
  localparam int NC = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0, cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic          cmd_write = 1'b0;
  logic [DW-1:0] cmd_wdata = '0;
  logic [SW-1:0] cmd_strb = '0;
  logic [2:0]    cmd_prot = '0;
  logic          rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic [NC-1:0] bus_sel;
  logic          bus_en, bus_wr, bus_wake;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [SW-1:0] bus_bytemask;
  logic [2:0]    bus_attr;
  logic          bus_rdy = 1'b0, bus_fault = 1'b0;
  logic [DW-1:0] bus_rdata = '0;

  int checks = 0;
  int errors = 0;
  int force_wait = -1;
  int wcnt = 0;

  apb_req_engine u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_write(cmd_write), .cmd_wdata(cmd_wdata),
    .cmd_strb(cmd_strb), .cmd_prot(cmd_prot), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .bus_sel(bus_sel),
    .bus_en(bus_en), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_bytemask(bus_bytemask), .bus_attr(bus_attr),
    .bus_wake(bus_wake), .bus_rdy(bus_rdy), .bus_rdata(bus_rdata),
    .bus_fault(bus_fault)
  );

  // R10 region table, lowest index first
  function automatic int region_of(logic [AW-1:0] a);
    if (a < 32'h1000) return 0;
    if (a < 32'h2000) return 1;
    if (a < 32'h4000) return 2;
    if (a >= 32'h8000 && a < 32'hC000) return 3;
    return -1;
  endfunction

  function automatic logic [DW-1:0] rd_pattern(logic [AW-1:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h5A3C_0000;
  endfunction

  function automatic logic fault_of(logic [AW-1:0] a);
    return a[3:2] == 2'b11;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // completer model: random or forced wait count per transfer
  always @(negedge clk) begin
    if (!rst_n || bus_sel == '0) begin
      bus_rdy = 1'b0; bus_fault = 1'b0; bus_rdata = '0;
    end else if (!bus_en) begin
      wcnt = (force_wait >= 0) ? force_wait : int'($urandom_range(0, 3));
      bus_rdy = 1'b0; bus_fault = 1'b0; bus_rdata = '0;
    end else if (wcnt == 0) begin
      bus_rdy = 1'b1; bus_fault = fault_of(bus_addr); bus_rdata = rd_pattern(bus_addr);
    end else begin
      wcnt--;
      bus_rdy = 1'b0; bus_fault = 1'b0; bus_rdata = 32'hDEAD_BEEF;
    end
  end

  // monitor state from the previous sample
  bit            pv = 1'b0;
  logic [NC-1:0] p_sel;
  logic          p_en, p_rdy, p_wr, p_wake, p_fault, p_cv, p_hs, p_hit;
  logic [AW-1:0] p_addr, h_addr;
  logic [DW-1:0] p_wdata, p_rdata, h_wdata;
  logic [SW-1:0] p_mask, h_strb;
  logic [2:0]    p_attr, h_prot;
  logic          h_wr;

  always @(negedge clk) begin
    #2;
    if (!rst_n) begin
      pv = 1'b0;
    end else begin
      if (pv) begin
        if (p_sel != 0 && !p_en)
          chk(bus_sel == p_sel && bus_en, "R2", "setup->access", {bus_sel, bus_en}, {p_sel, 1'b1});
        if (p_sel != 0 && p_en && !p_rdy)
          chk(bus_en && bus_sel == p_sel && bus_addr == p_addr && bus_wr == p_wr &&
              bus_wdata == p_wdata && bus_bytemask == p_mask && bus_attr == p_attr,
              "R3", "stall hold", bus_addr, p_addr);
        if (p_hs && p_hit) begin
          chk(bus_sel == NC'(1 << region_of(h_addr)) && !bus_en, "R10", "select",
              bus_sel, NC'(1 << region_of(h_addr)));
          chk(bus_addr == h_addr && bus_wr == h_wr && bus_wdata == h_wdata, "R4",
              "setup fields", bus_addr, h_addr);
          chk(bus_bytemask == (h_wr ? h_strb : 4'h0), "R5", "byte mask",
              bus_bytemask, h_wr ? h_strb : 4'h0);
          chk(bus_attr == h_prot, "R13", "attr", bus_attr, h_prot);
        end else if (p_sel != 0 && p_en && p_rdy) begin
          chk(bus_sel == 0 && !bus_en, "R4", "return idle", {bus_sel, bus_en}, 0);
        end
        if (p_sel != 0 && p_en && p_rdy)
          chk(rsp_valid && rsp_err == p_fault && rsp_rdata == (p_wr ? 32'h0 : p_rdata),
              "R6", "response", {rsp_valid, rsp_err, rsp_rdata},
              {1'b1, p_fault, p_wr ? 32'h0 : p_rdata});
        else if (p_hs && !p_hit)
          chk(rsp_valid && rsp_err && rsp_rdata == 0 && bus_sel == 0, "R11", "miss response",
              {rsp_valid, rsp_err, rsp_rdata, bus_sel}, {1'b1, 1'b1, 32'h0, 4'h0});
        else if (rsp_valid)
          chk(1'b0, "R6", "spurious response", rsp_valid, 0);
        if (p_sel == 0 && bus_sel != 0)
          chk(p_wake, "R8", "wake before select", p_wake, 1);
        if (!p_cv && !(p_sel != 0 && !(p_en && p_rdy)))
          chk(!bus_wake, "R9", "wake falls", bus_wake, 0);
      end
      if (bus_sel != 0) begin
        chk($onehot(bus_sel), "R10", "one select", bus_sel, 0);
        chk(bus_wake, "R7", "wake with select", bus_wake, 1);
        if (!bus_wr) chk(bus_bytemask == 0, "R5", "read mask", bus_bytemask, 0);
      end
      if (cmd_valid && bus_sel == 0 && !bus_wake)
        chk(!cmd_ready, "R8", "ready before wake", cmd_ready, 0);
      if (cmd_valid && cmd_ready)
        chk(bus_sel == 0 || (bus_en && bus_rdy), "R12", "accept window", bus_sel, 0);
      if (cmd_valid && bus_sel != 0 && bus_en && bus_rdy) begin
        if (region_of(cmd_addr) >= 0) chk(cmd_ready, "R4", "back-to-back accept", cmd_ready, 1);
        else chk(!cmd_ready, "R12", "miss at completion", cmd_ready, 0);
      end
      p_sel = bus_sel; p_en = bus_en; p_rdy = bus_rdy; p_wr = bus_wr; p_wake = bus_wake;
      p_fault = bus_fault; p_cv = cmd_valid; p_addr = bus_addr; p_wdata = bus_wdata;
      p_rdata = bus_rdata; p_mask = bus_bytemask; p_attr = bus_attr;
      p_hs = cmd_valid && cmd_ready; p_hit = region_of(cmd_addr) >= 0;
      h_addr = cmd_addr; h_wr = cmd_write; h_wdata = cmd_wdata; h_strb = cmd_strb; h_prot = cmd_prot;
      pv = 1'b1;
    end
  end

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic send(input logic [AW-1:0] a, input bit w, input logic [DW-1:0] d,
                      input logic [SW-1:0] s, input logic [2:0] p);
    cmd_valid = 1'b1; cmd_addr = a; cmd_write = w; cmd_wdata = d; cmd_strb = s; cmd_prot = p;
    forever begin
      #1;
      if (cmd_ready) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    cmd_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(bus_sel == 0 && !bus_en && !bus_wake && !rsp_valid && bus_addr == 0, "R1", "reset state",
        {bus_sel, bus_en, bus_wake, rsp_valid}, 0);
    rst_n = 1'b1;
    idle(2);
    // single transfers with fixed waits
    force_wait = 0; send(32'h0000_0810, 1'b0, 32'h0, 4'hF, 3'b010); idle(4);
    force_wait = 3; send(32'h0000_1804, 1'b1, 32'hCAFE_F00D, 4'b0101, 3'b101); idle(4);
    force_wait = 1; send(32'h0000_2C0C, 1'b0, 32'h1234_5678, 4'hF, 3'b001); idle(4);
    // unmapped addresses, including right past region edges
    send(32'h0000_4000, 1'b0, 32'h0, 4'h0, 3'b000);
    send(32'h0000_7FFC, 1'b1, 32'h9, 4'hF, 3'b000);
    send(32'h0000_C000, 1'b0, 32'h0, 4'h0, 3'b000); idle(3);
    // back-to-back across region and priority edges
    force_wait = 0;
    send(32'h0000_0FFC, 1'b1, 32'hA1, 4'h3, 3'b100);
    send(32'h0000_1000, 1'b0, 32'h0, 4'hF, 3'b011);
    send(32'h0000_3FFC, 1'b1, 32'hB2, 4'h8, 3'b110);
    send(32'h0000_8000, 1'b0, 32'h0, 4'hF, 3'b111);
    send(32'h0000_BFFC, 1'b1, 32'hC3, 4'hF, 3'b000);
    send(32'h0001_0000, 1'b0, 32'h0, 4'h0, 3'b000); // miss pending at completion
    force_wait = 2;
    send(32'h0000_2000, 1'b0, 32'h0, 4'hF, 3'b000);
    send(32'h0000_000C, 1'b1, 32'hD4, 4'hF, 3'b010);
    idle(5);
    force_wait = -1;
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      int k;
      k = $urandom_range(0, 9);
      case (k)
        0, 1: a = $urandom_range(0, 32'h0FFF);
        2:    a = 32'h1000 + $urandom_range(0, 32'h0FFF);
        3, 4: a = 32'h2000 + $urandom_range(0, 32'h1FFF);
        5, 6: a = 32'h8000 + $urandom_range(0, 32'h3FFF);
        7:    a = 32'h4000 + $urandom_range(0, 32'h3FFF);
        default: a = $urandom();
      endcase
      send(a, 1'($urandom_range(0, 1)), $urandom(), 4'($urandom()), 3'($urandom()));
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(6);
    finish_run();
  end
endmodule